// File: doc/BRIEF.md
# Serial TDM Timeslot Channel Multiplexer

This block frames a four-channel time-division link that uses one serial output and one serial input. A frame starts with an active-low frame pulse. Then come timeslots of `SLOT_BITS` bits, each sent most significant bit first:

- **Slot 0** carries a `D_BITS`-wide signalling field from an HDLC engine.
- **Slot 1** carries a control/status byte held in a local register.
- **Slots 2 and 3** are the two PCM voice slots.

Every later slot in the frame is left undriven.

On the receive side the block cuts the same slots out of the input stream. It hands the signalling bits, the control byte and one PCM byte to parallel ports, each with a single-cycle valid strobe.

A configuration register decides what each slot does:

- **Per-slot enables.** Each of the four slots has an enable. A disabled signalling or PCM slot is driven low. A disabled control slot is released (output enable low).
- **PCM priority.** One PCM byte serves both voice slots. When both are enabled, the priority slot wins, and by default that is slot 2.
- **Loopback modes.** Two modes loop the pins: input straight to output, or the generated output back into the receiver.

Output bits change on the rising clock edge and input bits are sampled on the falling edge. The parallel transmit data is copied into the block at the frame pulse.

Top module: `tdm_slot_mux`

## Requirements
- R1: Reset releases the output (ser_oe low), holds all valid strobes low and clears the configuration. It loads the control transmit byte with 0xFF. A configuration write (cfg_we) stores cfg_wdata with bit 0..3 = enable of slot 0..3, bit 4 = input-to-output loopback, bit 5 = output-to-input loopback. A control write (ctl_we) stores ctl_wdata.
- R2: Framing and idle slots:
  - When fp_n is low at a rising edge, the next bit period is frame bit 0.
  - Bit n of the frame belongs to slot n/8 at position n%8, and each slot is sent MSB first.
  - The output is released before the first frame pulse and in every slot numbered 4 or higher.
- R3: Slot 0 drives only its first two bit times, with d_tx[1] first; its other six bit times are released. With the slot 0 enable low, those two bits are driven as 0.
- R4: Slot 1 drives the control transmit byte when its enable is set and is released otherwise.
- R5: PCM transmit:
  - pcm_tx is sent in slot 2 when the slot 2 enable is set.
  - pcm_tx is sent in slot 3 when the slot 3 enable is set and the slot 2 enable is clear.
  - Otherwise a PCM slot is driven as all zeros.
- R6: d_tx, pcm_tx and the control transmit byte are copied at the frame pulse edge. Changing them later in the frame does not alter that frame's output.
- R7: The received slot 0 bits (first bit in d_rx[1]) and the received slot 1 byte are always delivered with a strobe, whatever the enables say.
- R8: pcm_rx is taken from slot 2 when its enable is set, otherwise from slot 3 when its enable is set. With neither enabled, no PCM strobe occurs.
- R9: In input-to-output loopback, ser_out follows ser_in directly. ser_oe is high only in the bit times of enabled slots (slot 0: its first two bits only).
- R10: In output-to-input loopback, the receiver takes the generated output stream instead of ser_in, and released bit times read as 1.
- R11: Each valid strobe is high for exactly one clock period, starting at the falling edge that samples the last bit of its field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, sampled on the rising edge |
| ser_in | input | 1 | Serial receive pin |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output driver enable (low = released) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 6 | Enables and loopback selects |
| ctl_we | input | 1 | Control transmit byte write strobe |
| ctl_wdata | input | SLOT_BITS | Control transmit byte |
| d_tx | input | D_BITS | Signalling bits to send in slot 0 |
| pcm_tx | input | SLOT_BITS | PCM byte to send |
| d_rx | output | D_BITS | Received signalling bits |
| d_rx_vld | output | 1 | Strobe for d_rx |
| ctl_rx | output | SLOT_BITS | Received control byte |
| ctl_rx_vld | output | 1 | Strobe for ctl_rx |
| pcm_rx | output | SLOT_BITS | Received PCM byte |
| pcm_rx_vld | output | 1 | Strobe for pcm_rx |

## Verification
The assertions watch the release rules on every cycle:

- no drive before framing or in high slots;
- the released tail of slot 0;
- forced-low signalling bits and the muted losing PCM slot;
- the pass-through in input-to-output loopback;
- strobe width, and no PCM strobe while both PCM enables are clear.

The actual bit values per slot, MSB-first order, capture of the data at the frame pulse, the reset value of the control byte, and the bytes recovered in each loopback mode can only be shown by the bench scenarios. There, a scoreboard compares each received field against the bits the bench itself drove or predicted.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

   // Configuration word, bit 0..3 = slot enables, 4 = in->out loop, 5 = out->in loop
   typedef struct packed {
      logic       lb_oi;
      logic       lb_io;
      logic [3:0] ch_en;
   } tdm_cfg_t;

   localparam int CFG_W    = $bits(tdm_cfg_t);
   localparam int SLOT_SIG = 0;
   localparam int SLOT_CTL = 1;
   localparam int SLOT_PA  = 2;
   localparam int SLOT_PB  = 3;

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
   parameter int FRAME_BITS = 256,
   localparam int CW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fp_n,
   output logic          active,
   output logic [CW-1:0] bit_idx
);

   localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         bit_idx <= '0;
      end else if (!fp_n) begin
         active  <= 1'b1;
         bit_idx <= '0;
      end else if (active) begin
         bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
      end
   end

endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
   import tdm_mux_pkg::*;
#(
   parameter int SLOT_BITS = 8,
   parameter int NUM_SLOTS = 32,
   parameter int D_BITS    = 2,
   localparam int BPW = $clog2(SLOT_BITS),
   localparam int SW  = $clog2(NUM_SLOTS)
) (
   input  logic                 active,
   input  logic [SW-1:0]        slot,
   input  logic [BPW-1:0]       bitpos,
   input  tdm_cfg_t             cfg,
   input  logic [1:0]           route,
   input  logic [D_BITS-1:0]    d_snap,
   input  logic [SLOT_BITS-1:0] ctl_snap,
   input  logic [SLOT_BITS-1:0] pcm_snap,
   input  logic                 ser_in,
   output logic                 ser_out,
   output logic                 ser_oe
);

   logic                 nrm_oe, nrm_d, en_oe;
   logic [D_BITS-1:0]    d_sh;
   logic [SLOT_BITS-1:0] ctl_sh, pcm_sh;
   logic [BPW-1:0]       d_sel;

   always_comb begin
      d_sel  = BPW'(D_BITS - 1) - bitpos;
      d_sh   = d_snap >> d_sel;
      ctl_sh = ctl_snap << bitpos;
      pcm_sh = pcm_snap << bitpos;
   end

   always_comb begin
      nrm_oe = 1'b0;
      nrm_d  = 1'b0;
      en_oe  = 1'b0;
      if (active) begin
         case (slot)
            SW'(SLOT_SIG): if (bitpos < BPW'(D_BITS)) begin
               nrm_oe = 1'b1;
               nrm_d  = cfg.ch_en[0] & d_sh[0];
               en_oe  = cfg.ch_en[0];
            end
            SW'(SLOT_CTL): begin
               nrm_oe = cfg.ch_en[1];
               nrm_d  = ctl_sh[SLOT_BITS-1];
               en_oe  = cfg.ch_en[1];
            end
            SW'(SLOT_PA): begin
               nrm_oe = 1'b1;
               nrm_d  = route[0] & pcm_sh[SLOT_BITS-1];
               en_oe  = cfg.ch_en[2];
            end
            SW'(SLOT_PB): begin
               nrm_oe = 1'b1;
               nrm_d  = route[1] & pcm_sh[SLOT_BITS-1];
               en_oe  = cfg.ch_en[3];
            end
            default: ;
         endcase
      end
   end

   assign ser_oe  = cfg.lb_io ? en_oe : nrm_oe;
   assign ser_out = cfg.lb_io ? ser_in : (nrm_oe & nrm_d);

endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
   import tdm_mux_pkg::*;
#(
   parameter int SLOT_BITS = 8,
   parameter int NUM_SLOTS = 32,
   parameter int D_BITS    = 2,
   localparam int BPW = $clog2(SLOT_BITS),
   localparam int SW  = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [SW-1:0]        slot,
   input  logic [BPW-1:0]       bitpos,
   input  logic [1:0]           route,
   input  logic                 rx_bit,
   output logic [D_BITS-1:0]    d_rx,
   output logic                 d_vld,
   output logic [SLOT_BITS-1:0] ctl_rx,
   output logic                 ctl_vld,
   output logic [SLOT_BITS-1:0] pcm_rx,
   output logic                 pcm_vld
);

   logic [SLOT_BITS-1:0] sh_q, sh_nx;
   logic                 last_bit, last_d, pcm_hit;

   always_comb begin
      sh_nx    = {sh_q[SLOT_BITS-2:0], rx_bit};
      last_bit = bitpos == BPW'(SLOT_BITS - 1);
      last_d   = bitpos == BPW'(D_BITS - 1);
      pcm_hit  = ((slot == SW'(SLOT_PA)) && route[0]) ||
                 ((slot == SW'(SLOT_PB)) && route[1]);
   end

   // Sampled on the falling edge, mid bit
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         d_rx    <= '0;
         ctl_rx  <= '0;
         pcm_rx  <= '0;
         d_vld   <= 1'b0;
         ctl_vld <= 1'b0;
         pcm_vld <= 1'b0;
      end else begin
         sh_q    <= sh_nx;
         d_vld   <= 1'b0;
         ctl_vld <= 1'b0;
         pcm_vld <= 1'b0;
         if (active) begin
            if (slot == SW'(SLOT_SIG) && last_d) begin
               d_rx  <= sh_nx[D_BITS-1:0];
               d_vld <= 1'b1;
            end
            if (slot == SW'(SLOT_CTL) && last_bit) begin
               ctl_rx  <= sh_nx;
               ctl_vld <= 1'b1;
            end
            if (pcm_hit && last_bit) begin
               pcm_rx  <= sh_nx;
               pcm_vld <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
   import tdm_mux_pkg::*;
#(
   parameter int SLOT_BITS = 8,
   parameter int NUM_SLOTS = 32,
   parameter int D_BITS    = 2,
   parameter bit B1_FIRST  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fp_n,
   input  logic                 ser_in,
   output logic                 ser_out,
   output logic                 ser_oe,
   input  logic                 cfg_we,
   input  logic [5:0]           cfg_wdata,
   input  logic                 ctl_we,
   input  logic [SLOT_BITS-1:0] ctl_wdata,
   input  logic [D_BITS-1:0]    d_tx,
   input  logic [SLOT_BITS-1:0] pcm_tx,
   output logic [D_BITS-1:0]    d_rx,
   output logic                 d_rx_vld,
   output logic [SLOT_BITS-1:0] ctl_rx,
   output logic                 ctl_rx_vld,
   output logic [SLOT_BITS-1:0] pcm_rx,
   output logic                 pcm_rx_vld
);

   localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS;
   localparam int CW  = $clog2(FRAME_BITS);
   localparam int BPW = $clog2(SLOT_BITS);
   localparam int SW  = $clog2(NUM_SLOTS);

   generate
      if (SLOT_BITS < 2 || (1 << BPW) != SLOT_BITS) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two of at least 2");
      end
      if (NUM_SLOTS < 4 || (1 << SW) != NUM_SLOTS) begin : g_bad_nslot
         $error("NUM_SLOTS must be a power of two of at least 4");
      end
      if (D_BITS < 1 || D_BITS > SLOT_BITS) begin : g_bad_d
         $error("D_BITS must lie in 1..SLOT_BITS");
      end
      if (CFG_W != 6) begin : g_bad_cfg
         $error("configuration word width mismatch");
      end
   endgenerate

   tdm_cfg_t             cfg_q;
   logic [SLOT_BITS-1:0] ctl_q, ctl_snap, pcm_snap;
   logic [D_BITS-1:0]    d_snap;
   logic                 frm_active, rx_bit;
   logic [CW-1:0]        bit_idx;
   logic [SW-1:0]        slot;
   logic [BPW-1:0]       bitpos;
   logic [1:0]           route;

   assign slot   = bit_idx[CW-1:BPW];
   assign bitpos = bit_idx[BPW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         ctl_q    <= '1;
         ctl_snap <= '1;
         pcm_snap <= '0;
         d_snap   <= '0;
      end else begin
         if (cfg_we) cfg_q <= tdm_cfg_t'(cfg_wdata);
         if (ctl_we) ctl_q <= ctl_wdata;
         if (!fp_n) begin
            ctl_snap <= ctl_q;
            pcm_snap <= pcm_tx;
            d_snap   <= d_tx;
         end
      end
   end

   // PCM slot selection when both voice slots are enabled
   generate
      if (B1_FIRST) begin : g_route_a
         assign route = {cfg_q.ch_en[3] & ~cfg_q.ch_en[2], cfg_q.ch_en[2]};
      end else begin : g_route_b
         assign route = {cfg_q.ch_en[3], cfg_q.ch_en[2] & ~cfg_q.ch_en[3]};
      end
   endgenerate

   tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) ctr_i (
      .clk(clk), .rst_n(rst_n), .fp_n(fp_n),
      .active(frm_active), .bit_idx(bit_idx)
   );

   tdm_tx_mux #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .D_BITS(D_BITS)) tx_i (
      .active(frm_active), .slot(slot), .bitpos(bitpos), .cfg(cfg_q),
      .route(route), .d_snap(d_snap), .ctl_snap(ctl_snap), .pcm_snap(pcm_snap),
      .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
   );

   assign rx_bit = cfg_q.lb_oi ? (ser_oe ? ser_out : 1'b1) : ser_in;

   tdm_rx_demux #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .D_BITS(D_BITS)) rx_i (
      .clk(clk), .rst_n(rst_n), .active(frm_active), .slot(slot),
      .bitpos(bitpos), .route(route), .rx_bit(rx_bit),
      .d_rx(d_rx), .d_vld(d_rx_vld), .ctl_rx(ctl_rx), .ctl_vld(ctl_rx_vld),
      .pcm_rx(pcm_rx), .pcm_vld(pcm_rx_vld)
   );

endmodule

// File: rtl/tdm_slot_mux_chk.sv
module tdm_slot_mux_chk #(
   parameter int SLOT_BITS = 8,
   parameter int NUM_SLOTS = 32,
   parameter int D_BITS    = 2,
   parameter bit B1_FIRST  = 1'b1,
   localparam int BPW = $clog2(SLOT_BITS),
   localparam int CW  = $clog2(NUM_SLOTS * SLOT_BITS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          active,
   input logic [CW-1:0] bit_idx,
   input logic [3:0]    ch_en,
   input logic          lb_io,
   input logic          ser_in,
   input logic          ser_out,
   input logic          ser_oe,
   input logic          d_vld,
   input logic          ctl_vld,
   input logic          pcm_vld
);

   logic [CW-BPW-1:0] slot;
   logic [BPW-1:0]    bp;
   assign slot = bit_idx[CW-1:BPW];
   assign bp   = bit_idx[BPW-1:0];

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !ser_oe); // R2
   AST_HIGH_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot > 3) |-> !ser_oe); // R2
   AST_SIG_TAIL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot == 0 && bp >= BPW'(D_BITS)) |-> !ser_oe); // R3
   AST_SIG_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot == 0 && bp < BPW'(D_BITS) && !ch_en[0] && !lb_io) |-> (ser_oe && !ser_out)); // R3
   AST_CTL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot == 1 && !ch_en[1]) |-> !ser_oe); // R4
   AST_LOSING_PCM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (B1_FIRST && active && slot == 3 && ch_en[2] && !lb_io) |-> (ser_oe && !ser_out)); // R5
   AST_LOOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_io && ser_oe) |-> (ser_out == ser_in)); // R9
   AST_PCM_NEEDS_EN: assert property (@(negedge clk) disable iff (!rst_n)
      pcm_vld |-> $past(ch_en[2] || ch_en[3])); // R8
   AST_SIG_VLD_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
      d_vld |=> !d_vld); // R11
   AST_CTL_VLD_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
      ctl_vld |=> !ctl_vld); // R11
   AST_PCM_VLD_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
      pcm_vld |=> !pcm_vld); // R11

endmodule

bind tdm_slot_mux tdm_slot_mux_chk #(
   .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .D_BITS(D_BITS), .B1_FIRST(B1_FIRST)
) chk_i (
   .clk(clk), .rst_n(rst_n), .active(frm_active), .bit_idx(bit_idx),
   .ch_en(cfg_q.ch_en), .lb_io(cfg_q.lb_io), .ser_in(ser_in),
   .ser_out(ser_out), .ser_oe(ser_oe), .d_vld(d_rx_vld),
   .ctl_vld(ctl_rx_vld), .pcm_vld(pcm_rx_vld)
);

// File: tb/tdm_slot_mux_tb_top.sv
module tdm_slot_mux_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 40;

   logic       clk = 1'b0, rst_n = 1'b0, fp_n = 1'b1, ser_in = 1'b0;
   logic       ser_out, ser_oe;
   logic       cfg_we = 1'b0, ctl_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic [7:0] ctl_wdata = '0, pcm_tx = '0, ctl_rx, pcm_rx;
   logic [1:0] d_tx = '0, d_rx;
   logic       d_rx_vld, ctl_rx_vld, pcm_rx_vld;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [9:0] exp_q[$];
   logic [5:0] m_cfg = '0;
   logic [7:0] m_ctl = 8'hFF, s_ctl, s_pcm;
   logic [1:0] s_d;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_slot_mux dut_i (
      .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ser_in(ser_in),
      .ser_out(ser_out), .ser_oe(ser_oe), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .d_tx(d_tx), .pcm_tx(pcm_tx),
      .d_rx(d_rx), .d_rx_vld(d_rx_vld), .ctl_rx(ctl_rx), .ctl_rx_vld(ctl_rx_vld),
      .pcm_rx(pcm_rx), .pcm_rx_vld(pcm_rx_vld)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Expected {oe, data} for frame bit i, from the requirements
   function automatic logic [1:0] exp_tx(int i, logic pin);
      int sl = i / 8, bp = i % 8;
      logic lbio = m_cfg[4];
      logic [3:0] en = m_cfg[3:0];
      logic oe = 0, d = 0;
      case (sl)
         0: if (bp < 2) begin oe = lbio ? en[0] : 1'b1; d = lbio ? pin : (en[0] & s_d[1-bp]); end
         1: begin oe = en[1]; d = lbio ? pin : s_ctl[7-bp]; end
         2: begin oe = lbio ? en[2] : 1'b1; d = lbio ? pin : (en[2] & s_pcm[7-bp]); end
         3: begin oe = lbio ? en[3] : 1'b1; d = lbio ? pin : (en[3] & ~en[2] & s_pcm[7-bp]); end
         default: ;
      endcase
      return {oe, oe & d};
   endfunction

   task automatic wr_cfg(input logic [5:0] v);
      @(posedge clk); #3 cfg_we = 1; cfg_wdata = v;
      @(posedge clk); #3 cfg_we = 0;
      m_cfg = v;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(posedge clk); #3 ctl_we = 1; ctl_wdata = v;
      @(posedge clk); #3 ctl_we = 0;
      m_ctl = v;
   endtask

   task automatic run_frame(input logic [NB-1:0] pat, input logic [1:0] d,
                            input logic [7:0] pcm, input bit mid_change, input string tag);
      logic [NB-1:0] rxv;
      logic [1:0] e;
      logic [7:0] b;
      string t;
      d_tx = d; pcm_tx = pcm;
      @(posedge clk); #1 fp_n = 0;
      s_d = d; s_pcm = pcm; s_ctl = m_ctl;
      for (int i = 0; i < NB; i++) begin
         e = exp_tx(i, pat[i]);
         rxv[i] = m_cfg[5] ? (e[1] ? e[0] : 1'b1) : pat[i];
      end
      exp_q.push_back({2'd0, 6'd0, rxv[0], rxv[1]});
      for (int k = 0; k < 8; k++) b[7-k] = rxv[8+k];
      exp_q.push_back({2'd1, b});
      if (m_cfg[2] || m_cfg[3]) begin
         for (int k = 0; k < 8; k++) b[7-k] = rxv[(m_cfg[2] ? 16 : 24) + k];
         exp_q.push_back({2'd2, b});
      end
      for (int i = 0; i < NB; i++) begin
         @(posedge clk); #1 fp_n = 1; ser_in = pat[i];
         if (mid_change && i == 3) begin d_tx = ~d; pcm_tx = ~pcm; ctl_we = 1; ctl_wdata = ~m_ctl; end
         if (mid_change && i == 4) ctl_we = 0;
         #1;
         e = exp_tx(i, pat[i]);
         if (tag != "") t = tag;
         else if (m_cfg[4]) t = "R9";
         else t = (i < 8) ? "R3" : (i < 16) ? "R4" : (i < 32) ? "R5" : "R2";
         chk(ser_oe == e[1], {t, " oe"}, ser_oe, e[1]);
         if (e[1]) chk(ser_out == e[0], {t, " data"}, ser_out, e[0]);
      end
      if (mid_change) m_ctl = ~m_ctl;
      repeat (2) @(posedge clk);
   endtask

   // Scoreboard monitor for receive strobes
   logic any_prev = 0;
   always @(posedge clk) begin
      logic [9:0] it;
      logic [1:0] kind;
      logic [7:0] val;
      string t;
      #4;
      if (rst_n && (d_rx_vld || ctl_rx_vld || pcm_rx_vld)) begin
         kind = d_rx_vld ? 2'd0 : ctl_rx_vld ? 2'd1 : 2'd2;
         val  = d_rx_vld ? {6'd0, d_rx} : ctl_rx_vld ? ctl_rx : pcm_rx;
         t = (kind == 2) ? "R8" : "R7";
         if (m_cfg[5]) t = {t, "/R10"};
         chk(!any_prev, "R11 strobe width", 1, 0);
         if (exp_q.size() == 0) chk(0, {t, " unexpected strobe"}, kind, 3);
         else begin
            it = exp_q.pop_front();
            chk(it[9:8] == kind, {t, " kind"}, kind, it[9:8]);
            chk(it[7:0] == val, {t, " value"}, val, it[7:0]);
         end
         any_prev = 1;
      end else any_prev = 0;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state, R2 no drive before a frame pulse
      chk(!ser_oe, "R1 oe after reset", ser_oe, 0);
      chk(!d_rx_vld && !ctl_rx_vld && !pcm_rx_vld, "R1 strobes", 1, 0);
      // R1: control byte defaults to FF, only slot 1 enabled
      wr_cfg(6'h02);
      run_frame(40'h00_F0_5A_C3_81, 2'b11, 8'h3C, 0, "");
      // all enabled: slot 2 wins (R5, R8)
      wr_ctl(8'h96);
      wr_cfg(6'h0F);
      run_frame(40'hFF_33_CC_69_A5, 2'b10, 8'hA5, 0, "");
      // slots 0 and 3 only
      wr_cfg(6'h09);
      run_frame(40'h12_E7_18_C6_02, 2'b01, 8'h4B, 0, "");
      // nothing enabled: forced low / released, D and control still received (R7)
      wr_cfg(6'h00);
      run_frame(40'hAA_55_0F_7E_03, 2'b11, 8'hFF, 0, "");
      // R6 mid-frame changes ignored
      wr_cfg(6'h0F);
      run_frame(40'h01_80_3C_D2_01, 2'b01, 8'h5A, 1, "R6");
      // R9 input-to-output loopback
      wr_cfg(6'h15);
      run_frame(40'hF3_9C_B5_6A_E2, 2'b00, 8'h00, 0, "");
      // R10 output-to-input loopback
      wr_ctl(8'hC9);
      wr_cfg(6'h2F);
      run_frame(40'h00_00_00_00_00, 2'b10, 8'h71, 0, "R10");
      // R10 released control slot reads as ones
      wr_cfg(6'h2D);
      run_frame(40'h00_00_00_00_00, 2'b01, 8'h8E, 0, "R10");
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, "R7/R8 missing strobes", exp_q.size(), 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule